// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small RISC-style core. It takes two 8-bit operands and a 5-bit operation code, produces an 8-bit result combinationally, and keeps an 8-bit status register that is updated on the clock edge that commits the operation. Each operation writes its own group of flags and leaves every other flag as it was. Carry-in for the carry-using operations is always taken from the status register's own carry bit.

The result and its write-enable are plain combinational outputs. The core writes the result back when `res_we` is high. Flags are committed by `op_valid`. The stream handshake style is not used here: there is no data queue and every operation completes in a single cycle, so no back-pressure exists. A second, independent path (`flag_wr`, `flag_idx`, `flag_val`) forces one chosen status bit to a given value. Bit-store and bit-load move a single bit between an operand and the T flag.

Status bit positions (bit 7 to bit 0): I, T, H, S, V, N, Z, C.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register reads 0x00. It changes only on a clock edge where `op_valid` or `flag_wr` is high. Flag positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: Operation codes 0 (add) and 1 (add with carry-in C) give a+b(+C) and update H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N, Z and S.
- R3: Codes 2 (subtract), 3 (subtract with borrow C), 4 (compare) and 5 (compare with borrow C) compute a-b(-C). They update H (borrow from bit 4), C (borrow), V, N, Z and S. Compares drive `res_we` low.
- R4: For codes 3 and 5, Z after the operation is 1 only if the difference is zero and Z was already 1.
- R5: Codes 6 (AND), 7 (OR) and 8 (XOR) update Z, N and S, and force V to 0. C, H, T and I keep their values.
- R6: Codes 11 (increment) and 12 (decrement) update Z, N, V and S and never change C. V is set when increment yields 0x80 or decrement yields 0x7F.
- R7: Code 9 returns 0xFF-a with C=1 and V=0. Code 10 returns 0x00-a and updates H, C, V, N, Z and S as a subtraction from zero.
- R8: Codes 13 (shift left), 14 (shift right), 15 (rotate left through C) and 16 (rotate right through C) behave as follows. Shifts insert 0 and rotates insert the old C. The bit moved out becomes C. V=N^C. Z, N and S are updated.
- R9: Code 17 (arithmetic shift right) keeps bit 7, moves bits 7..1 to 6..0 and puts bit 0 into C. It sets flags as in R8.
- R10: Code 18 swaps the two nibbles of a and changes no flag.
- R11: Code 19 copies a[bit_sel] into T, writes no result and changes no other flag. Code 20 returns a with bit bit_sel replaced by T and changes no flag.
- R12: When `flag_wr` is high, status bit `flag_idx` takes `flag_val` at the clock edge. On that bit this overrides any update from a committed operation in the same cycle.
- R13: S equals N XOR V after every committed operation that updates N or V.
- R14: Codes 21 to 31 return a, drive `res_we` low and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Commit the flag update of the current operation |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| bit_sel | input | 3 | Bit position for bit-store and bit-load |
| flag_wr | input | 1 | Force one status flag |
| flag_idx | input | 3 | Index of the flag to force |
| flag_val | input | 1 | Value to force |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result should be written back |
| status | output | 8 | Status register |

## Verification
The assertions check the flag-preservation rules on every cycle. Logic operations leave C and H alone, increment and decrement leave C alone, and nibble swap leaves the whole register alone. They also check the sticky zero of the borrow-chained forms, the S=N^V relation after N/V updates, and the force path. Only the bench's scenarios can show arithmetic correctness. This covers the exact carry, half-carry and overflow values at boundaries such as 0x7F+1, 0x80 negation, and chained multi-byte compares, all checked against a behavioural model on every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NFLAG  = 8;
  localparam int FIDX_W = $clog2(NFLAG);

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_BST  = 5'd19,
    OP_BLD  = 5'd20
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int HB  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW:0] full;
  logic [HB:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
      half = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      half = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
    end
    sum   = full[DW-1:0];
    c_out = full[DW];
    h_out = half[HB];
    if (sub) v_out = (x[MSB] != y[MSB]) && (sum[MSB] != x[MSB]);
    else     v_out = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          tflag,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          v_out,
  output logic          t_out
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2;
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    res   = a;
    c_out = cin;
    v_out = 1'b0;
    t_out = a[bsel];
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_INC: begin res = a + 1'b1; v_out = (res == MIN_NEG); end
      OP_DEC: begin res = a - 1'b1; v_out = (res == MAX_POS); end
      OP_LSL: begin res = {a[MSB-1:0], 1'b0};  c_out = a[MSB]; end
      OP_LSR: begin res = {1'b0, a[MSB:1]};    c_out = a[0];   end
      OP_ROL: begin res = {a[MSB-1:0], cin};   c_out = a[MSB]; end
      OP_ROR: begin res = {cin, a[MSB:1]};     c_out = a[0];   end
      OP_ASR: begin res = {a[MSB], a[MSB:1]};  c_out = a[0];   end
      OP_SWAP: res = {a[HB-1:0], a[DW-1:HB]};
      OP_BLD: begin res = a; res[bsel] = tflag; end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int NF = 8,
  localparam int IW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [NF-1:0] upd_mask,
  input  logic [NF-1:0] upd_val,
  input  logic          force_en,
  input  logic [IW-1:0] force_idx,
  input  logic          force_val,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] nxt;

  always_comb begin
    nxt = flags;
    if (commit) nxt = (flags & ~upd_mask) | (upd_val & upd_mask);
    if (force_en) nxt[force_idx] = force_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  AST_FORCE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> flags[$past(force_idx)] == $past(force_val)); // R12
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !force_en) |=> $stable(flags)); // R1
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [4:0]             op_sel,
  input  logic [DW-1:0]          opnd_a,
  input  logic [DW-1:0]          opnd_b,
  input  logic [$clog2(DW)-1:0]  bit_sel,
  input  logic                   flag_wr,
  input  logic [FIDX_W-1:0]      flag_idx,
  input  logic                   flag_val,
  output logic [DW-1:0]          result,
  output logic                   res_we,
  output logic [NFLAG-1:0]       status
);
  localparam int MSB = DW - 1;
  localparam logic [NFLAG-1:0] M_ARITH = NFLAG'((1 << FL_H) | (1 << FL_S) | (1 << FL_V) |
                                                (1 << FL_N) | (1 << FL_Z) | (1 << FL_C));
  localparam logic [NFLAG-1:0] M_ZNVS  = NFLAG'((1 << FL_S) | (1 << FL_V) | (1 << FL_N) | (1 << FL_Z));
  localparam logic [NFLAG-1:0] M_ZCNVS = M_ZNVS | NFLAG'(1 << FL_C);

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  logic          is_neg, is_chain, is_sub;
  logic [DW-1:0] as_x, as_y, as_sum, bo_res;
  logic          as_cin, as_c, as_h, as_v, bo_c, bo_v, bo_t;
  logic [NFLAG-1:0] mask, nf;

  assign is_neg   = (op == OP_NEG);
  assign is_chain = (op == OP_SBC) || (op == OP_CPC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
                    (op == OP_CPC) || is_neg;
  assign as_x     = is_neg ? '0 : opnd_a;
  assign as_y     = is_neg ? opnd_a : opnd_b;
  assign as_cin   = ((op == OP_ADC) || is_chain) ? status[FL_C] : 1'b0;

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(is_sub),
    .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(status[FL_C]), .tflag(status[FL_T]),
    .bsel(bit_sel), .res(bo_res), .c_out(bo_c), .v_out(bo_v), .t_out(bo_t)
  );

  always_comb begin
    result = opnd_a;
    res_we = 1'b0;
    mask   = '0;
    nf     = status;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        result  = as_sum;
        res_we  = (op != OP_CP) && (op != OP_CPC);
        mask    = M_ARITH;
        nf[FL_C] = as_c;
        nf[FL_H] = as_h;
        nf[FL_V] = as_v;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = bo_res; res_we = 1'b1; mask = M_ZNVS; nf[FL_V] = 1'b0;
      end
      OP_COM: begin
        result = bo_res; res_we = 1'b1; mask = M_ZCNVS;
        nf[FL_C] = 1'b1; nf[FL_V] = 1'b0;
      end
      OP_INC, OP_DEC: begin
        result = bo_res; res_we = 1'b1; mask = M_ZNVS; nf[FL_V] = bo_v;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        result = bo_res; res_we = 1'b1; mask = M_ZCNVS;
        nf[FL_C] = bo_c; nf[FL_V] = bo_res[MSB] ^ bo_c;
      end
      OP_SWAP, OP_BLD: begin result = bo_res; res_we = 1'b1; end
      OP_BST: begin mask = NFLAG'(1 << FL_T); nf[FL_T] = bo_t; end
      default: ;
    endcase
    nf[FL_N] = result[MSB];
    nf[FL_Z] = (result == '0) && (!is_chain || status[FL_Z]);
    nf[FL_S] = nf[FL_N] ^ nf[FL_V];
  end

  alu8_status #(.NF(NFLAG)) u_status (
    .clk(clk), .rst_n(rst_n), .commit(op_valid), .upd_mask(mask), .upd_val(nf),
    .force_en(flag_wr), .force_idx(flag_idx), .force_val(flag_val), .flags(status)
  );

  AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && (op == OP_AND || op == OP_OR || op == OP_XOR))
    |=> ($stable(status[FL_C]) && $stable(status[FL_H]) && !status[FL_V])); // R5
  AST_INCDEC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && (op == OP_INC || op == OP_DEC))
    |=> $stable(status[FL_C])); // R6
  AST_CHAIN_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && is_chain && !status[FL_Z]) |=> !status[FL_Z]); // R4
  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && (op == OP_SWAP || op == OP_BLD)) |=> $stable(status)); // R10
  AST_S_TRACKS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_wr && mask[FL_N])
    |=> status[FL_S] == (status[FL_N] ^ status[FL_V])); // R13
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CP || op == OP_CPC || op == OP_BST || op_sel > 5'd20) |-> !res_we); // R3
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [2:0] bit_sel = '0;
  logic       flag_wr = 1'b0;
  logic [2:0] flag_idx = '0;
  logic       flag_val = 1'b0;
  logic [7:0] result, status;
  logic       res_we;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mst = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel), .flag_wr(flag_wr),
    .flag_idx(flag_idx), .flag_val(flag_val), .result(result), .res_we(res_we),
    .status(status)
  );

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int op);
    if (op <= 1) return "R2";
    if (op == 3 || op == 5) return "R4";
    if (op <= 5) return "R3";
    if (op <= 8) return "R5";
    if (op <= 10) return "R7";
    if (op <= 12) return "R6";
    if (op <= 16) return "R8";
    if (op == 17) return "R9";
    if (op == 18) return "R10";
    if (op <= 20) return "R11";
    return "R14";
  endfunction

  task automatic model(input int op, input int a, input int b, input int bs,
                       input logic [7:0] st, output int r, output bit we,
                       output logic [7:0] ns);
    int c, d, x, y, sv;
    bit nz;
    c = st[0]; ns = st; we = 1; nz = 1; r = a;
    case (op)
      0, 1: begin
        c = (op == 1) ? c : 0;
        d = a + b + c; r = d & 255; ns[0] = d > 255;
        ns[5] = ((a & 15) + (b & 15) + c) > 15;
        sv = sx(a) + sx(b) + c; ns[3] = (sv > 127 || sv < -128);
      end
      2, 3, 4, 5, 10: begin
        x = (op == 10) ? 0 : a; y = (op == 10) ? a : b;
        c = (op == 3 || op == 5) ? c : 0;
        d = x - y - c; r = d & 255; ns[0] = d < 0;
        ns[5] = ((x & 15) - (y & 15) - c) < 0;
        sv = sx(x) - sx(y) - c; ns[3] = (sv > 127 || sv < -128);
        we = !(op == 4 || op == 5);
      end
      6: begin r = a & b; ns[3] = 0; end
      7: begin r = a | b; ns[3] = 0; end
      8: begin r = a ^ b; ns[3] = 0; end
      9: begin r = 255 - a; ns[0] = 1; ns[3] = 0; end
      11: begin r = (a + 1) & 255; ns[3] = (a == 127); end
      12: begin r = (a + 255) & 255; ns[3] = (a == 128); end
      13: begin r = (a << 1) & 255; ns[0] = a >> 7; end
      14: begin r = a >> 1; ns[0] = a & 1; end
      15: begin r = ((a << 1) | c) & 255; ns[0] = a >> 7; end
      16: begin r = (c << 7) | (a >> 1); ns[0] = a & 1; end
      17: begin r = (a & 128) | (a >> 1); ns[0] = a & 1; end
      18: begin r = ((a & 15) << 4) | (a >> 4); nz = 0; end
      19: begin we = 0; nz = 0; ns[6] = (a >> bs) & 1; end
      20: begin r = st[6] ? (a | (1 << bs)) : (a & ~(1 << bs)) & 255; nz = 0; end
      default: begin we = 0; nz = 0; end
    endcase
    if (op >= 13 && op <= 17) ns[3] = ((r >> 7) & 1) ^ ns[0];
    if (nz) begin
      ns[2] = (r >> 7) & 1;
      ns[1] = (r == 0) && ((op == 3 || op == 5) ? st[1] : 1'b1);
      ns[4] = ns[2] ^ ns[3];
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int op, int a, int b, int bs, bit ov, bit fw, int fi, bit fv);
    int r; bit we; logic [7:0] ns;
    @(negedge clk);
    op_sel = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; bit_sel = bs[2:0];
    op_valid = ov; flag_wr = fw; flag_idx = fi[2:0]; flag_val = fv;
    #1;
    model(op, a, b, bs, mst, r, we, ns);
    if (!ov) ns = mst;
    if (fw) ns[fi] = fv;
    check(tag_of(op), "result", result, r);
    check(tag_of(op), "res_we", res_we, we);
    @(posedge clk); #1;
    check(fw ? "R12" : (ov ? tag_of(op) : "R1"), "status", status, ns);
    mst = status;
    if (status == ns && ov && !fw && op <= 17 && op != 18)
      check("R13", "S=N^V", status[4], status[2] ^ status[3]);
  endtask

  task automatic setf(int idx, bit v);
    step(21, 0, 0, 0, 0, 1, idx, v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "reset status", status, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    mst = 8'h00;
    step(0, 8'h12, 8'h34, 0, 0, 0, 0, 0);           // R1 no commit
    step(0, 8'h7F, 8'h01, 0, 1, 0, 0, 0);           // R2 overflow, half carry
    step(0, 8'hFF, 8'h01, 0, 1, 0, 0, 0);           // R2 carry, zero
    step(1, 8'h10, 8'h20, 0, 1, 0, 0, 0);           // R2 adc with C=1
    step(2, 8'h80, 8'h01, 0, 1, 0, 0, 0);           // R3 signed overflow
    step(4, 8'h05, 8'h05, 0, 1, 0, 0, 0);           // R3 compare equal
    step(5, 8'h00, 8'h00, 0, 1, 0, 0, 0);           // R4 chain zero with Z set
    step(2, 8'h01, 8'h00, 0, 1, 0, 0, 0);           // clear Z
    step(3, 8'h00, 8'h00, 0, 1, 0, 0, 0);           // R4 zero diff, Z stays 0
    setf(0, 1);                                      // R12 set C
    step(6, 8'hF0, 8'h80, 0, 1, 0, 0, 0);           // R5 C kept
    step(11, 8'h7F, 0, 0, 1, 0, 0, 0);              // R6 inc overflow, C kept
    step(12, 8'h80, 0, 0, 1, 0, 0, 0);              // R6 dec overflow
    step(10, 8'h80, 0, 0, 1, 0, 0, 0);              // R7 neg 0x80
    step(10, 8'h00, 0, 0, 1, 0, 0, 0);              // R7 neg zero
    step(9, 8'h00, 0, 0, 1, 0, 0, 0);               // R7 com
    step(15, 8'h80, 0, 0, 1, 0, 0, 0);              // R8 rotate out
    step(16, 8'h01, 0, 0, 1, 0, 0, 0);              // R8 rotate right
    step(17, 8'h81, 0, 0, 1, 0, 0, 0);              // R9 asr
    step(18, 8'hA5, 0, 0, 1, 0, 0, 0);              // R10 swap
    step(19, 8'h08, 0, 3, 1, 0, 0, 0);              // R11 bst
    step(20, 8'h00, 0, 5, 1, 0, 0, 0);              // R11 bld
    step(25, 8'h3C, 8'h11, 0, 1, 0, 0, 0);          // R14 unused code
    step(0, 8'hFF, 8'h01, 0, 1, 1, 0, 0);           // R12 force beats op on C
    setf(7, 1);                                      // R12 set I
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = $urandom_range(0, 31);
      if (op > 22 && ($urandom_range(0, 3) != 0)) op = $urandom_range(0, 20);
      step(op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7),
           $urandom_range(0, 7) != 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 7), $urandom_range(0, 1));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule